// File: doc/BRIEF.md
# Audio Port Crossbar Switch

This block is a routing fabric for serial audio. It sits between five external audio ports and three internal audio controllers. Each external port carries a bit clock, a frame sync and two data pins. Each internal controller, an I2S unit for example, sends and receives the same kinds of lines. A small 32-bit register interface sets up the whole routing. Every programmed value takes effect as written. The block does not check whether a route makes sense.

On the port side, each port has a register that names its source. The source is either one controller or another port. For a port-to-port link the register also holds two more things. One is a master flag: the master port lets its pad clocks come in and forwards them to its partner. The other is a per-pin direction for the two data pins. On the controller side, each controller has a register with three separate selects. They choose which port feeds its clock, its first data lane and its second data lane. One controller's outputs can be sent to several ports at once, so the same audio can go out on all of them.

Top module: `audio_port_xbar`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0. Every port then follows controller 1: its clock and frame sync come from controller 1 with the clock enable high, and both data pins drive controller 1's transmit lanes.
- R2: Port registers sit at byte addresses 0x00, 0x04, 0x08, 0x0C and 0x10, and keep only bits 31, 30, 29 and 4:0. Controller registers sit at 0x40, 0x44 and 0x48, and keep only bits 31:24 and 3:0. All other bits read 0. Any other address, misaligned addresses included, reads 0 and ignores writes.
- R3: A write changes routing and readback only from the clock edge that captures it. Before that edge, the outputs still show the old setting.
- R4: When a port register's bits 4:0 hold 0, 1 or 2, that port's clock, frame sync and data outputs follow controller 1, 2 or 3, and its clock enable is 1. This holds whatever the master bit is.
- R5: When bits 4:0 hold 16+q, for q from 0 to 4, and bit 31 is 0 (slave), the port drives its clock and frame sync from the pad inputs of port q+1, with its clock enable at 1.
- R6: When bits 4:0 hold 16+q and bit 31 is 1 (master), the port's clock enable is 0 and its clock and frame sync outputs are 0.
- R7: Bit 30 sets data pin 1 and bit 29 sets data pin 2, each on its own. A value of 1 means receive: enable 0 and output 0. A value of 0 means transmit: enable 1, and the pin carries the matching lane of the selected source (controller transmit lane, or the partner port's pad input).
- R8: Source codes 3 to 15 and 21 to 31 are reserved. They put 0 on the clock, frame sync and data outputs, with the clock enable at 1. The data enables still follow bits 30 and 29.
- R9: In a controller register, bits 3:0 pick the port (code k means port k+1, for k from 0 to 4) whose pad clock and frame sync reach the controller. Bits 27:24 pick the port for receive lane 1 and bits 31:28 the port for lane 2. The three selects are independent.
- R10: Controller select codes 5 to 15 put 0 on the affected controller inputs.
- R11: Several ports may select the same controller. Each of them then carries that controller's lines at the same time.
- R12: Combinations that make no sense take effect as written. A port may select itself as a slave, and two linked ports may both be masters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| ctl_bclk_tx | input | 3 | Bit clock from each controller |
| ctl_fs_tx | input | 3 | Frame sync from each controller |
| ctl_d1_tx | input | 3 | Transmit lane 1 from each controller |
| ctl_d2_tx | input | 3 | Transmit lane 2 from each controller |
| ctl_bclk_rx | output | 3 | Bit clock delivered to each controller |
| ctl_fs_rx | output | 3 | Frame sync delivered to each controller |
| ctl_d1_rx | output | 3 | Receive lane 1 delivered to each controller |
| ctl_d2_rx | output | 3 | Receive lane 2 delivered to each controller |
| pad_bclk_in | input | 5 | Bit clock pad input of each port |
| pad_fs_in | input | 5 | Frame sync pad input of each port |
| pad_d1_in | input | 5 | Data pin 1 pad input of each port |
| pad_d2_in | input | 5 | Data pin 2 pad input of each port |
| pad_bclk_out | output | 5 | Bit clock pad output of each port |
| pad_fs_out | output | 5 | Frame sync pad output of each port |
| pad_clk_oe | output | 5 | Drive enable for bit clock and frame sync |
| pad_d1_out | output | 5 | Data pin 1 pad output |
| pad_d1_oe | output | 5 | Data pin 1 drive enable |
| pad_d2_out | output | 5 | Data pin 2 pad output |
| pad_d2_oe | output | 5 | Data pin 2 drive enable |

## Verification
The only state in the block is the register contents. The routing paths are purely combinational from those registers and the live pad and controller lines. So a wrong stored field shows up on the pads or on the controller inputs in the first cycle after the write edge, as long as the input lines are moving. The bench changes every pad and controller line between checks so that a wrong select cannot hide behind matching values. It also reads each register back, which exposes a bad bit mask or a bad address decode on the very next check.

// File: rtl/apx_pkg.sv
// Shared field layout and types of the audio port crossbar.
// Assumes 32-bit registers, and at most 16 ports and 16 controllers.
package apx_pkg;
    localparam int REG_W         = 32;
    localparam int SRC_W         = 5;
    localparam int PSEL_W        = 4;
    localparam int PEER_BASE     = 16;
    localparam int PORT_REG_BASE = 'h00;
    localparam int CTL_REG_BASE  = 'h40;
    localparam int REG_STRIDE    = 4;
    localparam int BIT_MASTER    = 31;
    localparam int BIT_D1_RX     = 30;
    localparam int BIT_D2_RX     = 29;
    localparam int LSB_CLK_PORT  = 0;
    localparam int LSB_D1_PORT   = 24;
    localparam int LSB_D2_PORT   = 28;

    typedef struct packed {
        logic             master;
        logic             d1_rx;
        logic             d2_rx;
        logic [SRC_W-1:0] src;
    } port_cfg_t;

    typedef struct packed {
        logic [PSEL_W-1:0] d2_port;
        logic [PSEL_W-1:0] d1_port;
        logic [PSEL_W-1:0] clk_port;
    } ctl_cfg_t;

    // Extract the kept fields of a port register word.
    function automatic port_cfg_t port_from_word(input logic [REG_W-1:0] w);
        port_cfg_t r;
        r.master = w[BIT_MASTER];
        r.d1_rx  = w[BIT_D1_RX];
        r.d2_rx  = w[BIT_D2_RX];
        r.src    = w[SRC_W-1:0];
        return r;
    endfunction

    // Rebuild the readback word of a port register.
    function automatic logic [REG_W-1:0] port_to_word(input port_cfg_t c);
        logic [REG_W-1:0] w;
        w             = '0;
        w[BIT_MASTER] = c.master;
        w[BIT_D1_RX]  = c.d1_rx;
        w[BIT_D2_RX]  = c.d2_rx;
        w[SRC_W-1:0]  = c.src;
        return w;
    endfunction

    // Extract the kept fields of a controller register word.
    function automatic ctl_cfg_t ctl_from_word(input logic [REG_W-1:0] w);
        ctl_cfg_t r;
        r.clk_port = w[LSB_CLK_PORT +: PSEL_W];
        r.d1_port  = w[LSB_D1_PORT +: PSEL_W];
        r.d2_port  = w[LSB_D2_PORT +: PSEL_W];
        return r;
    endfunction

    // Rebuild the readback word of a controller register.
    function automatic logic [REG_W-1:0] ctl_to_word(input ctl_cfg_t c);
        logic [REG_W-1:0] w;
        w                         = '0;
        w[LSB_CLK_PORT +: PSEL_W] = c.clk_port;
        w[LSB_D1_PORT +: PSEL_W]  = c.d1_port;
        w[LSB_D2_PORT +: PSEL_W]  = c.d2_port;
        return w;
    endfunction
endpackage

// File: rtl/apx_cfg_regs.sv
// Routing register file: one register per port and one per controller.
// Decodes word-aligned byte addresses. Unmapped or misaligned accesses read
// 0 and have no effect. Writes land on the capturing clock edge.
module apx_cfg_regs
    import apx_pkg::*;
#(
    parameter int N_PORT = 5,
    parameter int N_CTL  = 3,
    parameter int AW     = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [AW-1:0]          cfg_addr,
    input  logic [REG_W-1:0]       cfg_wdata,
    output port_cfg_t [N_PORT-1:0] port_cfg,
    output ctl_cfg_t  [N_CTL-1:0]  ctl_cfg,
    output logic [REG_W-1:0]       cfg_rdata
);
    function automatic logic [AW-1:0] port_addr(input int idx);
        return AW'(PORT_REG_BASE + REG_STRIDE * idx);
    endfunction

    function automatic logic [AW-1:0] ctl_addr(input int idx);
        return AW'(CTL_REG_BASE + REG_STRIDE * idx);
    endfunction

    // Capture register writes; clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_cfg <= '0;
            ctl_cfg  <= '0;
        end else if (cfg_we) begin
            for (int p = 0; p < N_PORT; p++)
                if (cfg_addr == port_addr(p)) port_cfg[p] <= port_from_word(cfg_wdata);
            for (int c = 0; c < N_CTL; c++)
                if (cfg_addr == ctl_addr(c)) ctl_cfg[c] <= ctl_from_word(cfg_wdata);
        end
    end

    // Return the addressed register, or 0 when nothing matches.
    always_comb begin
        cfg_rdata = '0;
        for (int p = 0; p < N_PORT; p++)
            if (cfg_addr == port_addr(p)) cfg_rdata = port_to_word(port_cfg[p]);
        for (int c = 0; c < N_CTL; c++)
            if (cfg_addr == ctl_addr(c)) cfg_rdata = ctl_to_word(ctl_cfg[c]);
    end
endmodule

// File: rtl/apx_port_route.sv
// Pad-side routing of one port: picks a controller or a peer port as the
// source and applies the master and pin-direction settings.
// Assumes codes below N_CTL are controllers, codes PEER_BASE+q are peers,
// and every other code is reserved and routes 0.
module apx_port_route
    import apx_pkg::*;
#(
    parameter int N_PORT = 5,
    parameter int N_CTL  = 3
) (
    input  port_cfg_t         cfg,
    input  logic [N_CTL-1:0]  ctl_bclk_tx,
    input  logic [N_CTL-1:0]  ctl_fs_tx,
    input  logic [N_CTL-1:0]  ctl_d1_tx,
    input  logic [N_CTL-1:0]  ctl_d2_tx,
    input  logic [N_PORT-1:0] pad_bclk_in,
    input  logic [N_PORT-1:0] pad_fs_in,
    input  logic [N_PORT-1:0] pad_d1_in,
    input  logic [N_PORT-1:0] pad_d2_in,
    output logic              bclk_out,
    output logic              fs_out,
    output logic              clk_oe,
    output logic              d1_out,
    output logic              d1_oe,
    output logic              d2_out,
    output logic              d2_oe
);
    logic src_bclk, src_fs, src_d1, src_d2, from_peer;

    // Gather the four lines of the selected source.
    always_comb begin
        src_bclk  = 1'b0;
        src_fs    = 1'b0;
        src_d1    = 1'b0;
        src_d2    = 1'b0;
        from_peer = 1'b0;
        for (int c = 0; c < N_CTL; c++) begin
            if (cfg.src == SRC_W'(c)) begin
                src_bclk = ctl_bclk_tx[c];
                src_fs   = ctl_fs_tx[c];
                src_d1   = ctl_d1_tx[c];
                src_d2   = ctl_d2_tx[c];
            end
        end
        for (int q = 0; q < N_PORT; q++) begin
            if (cfg.src == SRC_W'(PEER_BASE + q)) begin
                from_peer = 1'b1;
                src_bclk  = pad_bclk_in[q];
                src_fs    = pad_fs_in[q];
                src_d1    = pad_d1_in[q];
                src_d2    = pad_d2_in[q];
            end
        end
    end

    // Apply the master role and the pin directions to the pad drivers.
    always_comb begin
        clk_oe   = !(from_peer && cfg.master);
        bclk_out = clk_oe && src_bclk;
        fs_out   = clk_oe && src_fs;
        d1_oe    = !cfg.d1_rx;
        d1_out   = d1_oe && src_d1;
        d2_oe    = !cfg.d2_rx;
        d2_out   = d2_oe && src_d2;
    end
endmodule

// File: rtl/apx_ctl_route.sv
// Controller-side routing: picks, independently, the port that feeds the
// controller's clock pair and each of its two receive lanes.
// Assumes port codes of N_PORT or above are reserved and route 0.
module apx_ctl_route
    import apx_pkg::*;
#(
    parameter int N_PORT = 5
) (
    input  ctl_cfg_t          cfg,
    input  logic [N_PORT-1:0] pad_bclk_in,
    input  logic [N_PORT-1:0] pad_fs_in,
    input  logic [N_PORT-1:0] pad_d1_in,
    input  logic [N_PORT-1:0] pad_d2_in,
    output logic              bclk_rx,
    output logic              fs_rx,
    output logic              d1_rx,
    output logic              d2_rx
);
    // Select each inward line from its own port code.
    always_comb begin
        bclk_rx = 1'b0;
        fs_rx   = 1'b0;
        d1_rx   = 1'b0;
        d2_rx   = 1'b0;
        for (int q = 0; q < N_PORT; q++) begin
            if (cfg.clk_port == PSEL_W'(q)) begin
                bclk_rx = pad_bclk_in[q];
                fs_rx   = pad_fs_in[q];
            end
            if (cfg.d1_port == PSEL_W'(q)) d1_rx = pad_d1_in[q];
            if (cfg.d2_port == PSEL_W'(q)) d2_rx = pad_d2_in[q];
        end
    end
endmodule

// File: rtl/audio_port_xbar.sv
// Top level of the audio port crossbar: the register file, one pad-side
// router per port and one inward router per controller.
// Assumes all lines share the register clock domain and the pads are
// tri-stated outside this block using the enable outputs.
module audio_port_xbar
    import apx_pkg::*;
#(
    parameter int N_PORT = 5,
    parameter int N_CTL  = 3,
    parameter int AW     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic [N_CTL-1:0]  ctl_bclk_tx,
    input  logic [N_CTL-1:0]  ctl_fs_tx,
    input  logic [N_CTL-1:0]  ctl_d1_tx,
    input  logic [N_CTL-1:0]  ctl_d2_tx,
    output logic [N_CTL-1:0]  ctl_bclk_rx,
    output logic [N_CTL-1:0]  ctl_fs_rx,
    output logic [N_CTL-1:0]  ctl_d1_rx,
    output logic [N_CTL-1:0]  ctl_d2_rx,
    input  logic [N_PORT-1:0] pad_bclk_in,
    input  logic [N_PORT-1:0] pad_fs_in,
    input  logic [N_PORT-1:0] pad_d1_in,
    input  logic [N_PORT-1:0] pad_d2_in,
    output logic [N_PORT-1:0] pad_bclk_out,
    output logic [N_PORT-1:0] pad_fs_out,
    output logic [N_PORT-1:0] pad_clk_oe,
    output logic [N_PORT-1:0] pad_d1_out,
    output logic [N_PORT-1:0] pad_d1_oe,
    output logic [N_PORT-1:0] pad_d2_out,
    output logic [N_PORT-1:0] pad_d2_oe
);
    port_cfg_t [N_PORT-1:0] port_cfg;
    ctl_cfg_t  [N_CTL-1:0]  ctl_cfg;

    apx_cfg_regs #(.N_PORT(N_PORT), .N_CTL(N_CTL), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .port_cfg  (port_cfg),
        .ctl_cfg   (ctl_cfg),
        .cfg_rdata (cfg_rdata)
    );

    for (genvar p = 0; p < N_PORT; p++) begin : g_port
        apx_port_route #(.N_PORT(N_PORT), .N_CTL(N_CTL)) u_route (
            .cfg         (port_cfg[p]),
            .ctl_bclk_tx (ctl_bclk_tx),
            .ctl_fs_tx   (ctl_fs_tx),
            .ctl_d1_tx   (ctl_d1_tx),
            .ctl_d2_tx   (ctl_d2_tx),
            .pad_bclk_in (pad_bclk_in),
            .pad_fs_in   (pad_fs_in),
            .pad_d1_in   (pad_d1_in),
            .pad_d2_in   (pad_d2_in),
            .bclk_out    (pad_bclk_out[p]),
            .fs_out      (pad_fs_out[p]),
            .clk_oe      (pad_clk_oe[p]),
            .d1_out      (pad_d1_out[p]),
            .d1_oe       (pad_d1_oe[p]),
            .d2_out      (pad_d2_out[p]),
            .d2_oe       (pad_d2_oe[p])
        );
    end

    for (genvar c = 0; c < N_CTL; c++) begin : g_ctl
        apx_ctl_route #(.N_PORT(N_PORT)) u_route (
            .cfg         (ctl_cfg[c]),
            .pad_bclk_in (pad_bclk_in),
            .pad_fs_in   (pad_fs_in),
            .pad_d1_in   (pad_d1_in),
            .pad_d2_in   (pad_d2_in),
            .bclk_rx     (ctl_bclk_rx[c]),
            .fs_rx       (ctl_fs_rx[c]),
            .d1_rx       (ctl_d1_rx[c]),
            .d2_rx       (ctl_d2_rx[c])
        );
    end
endmodule

// File: rtl/apx_xbar_chk.sv
// Property checker for the audio port crossbar, attached by bind.
// Relates stored register fields to the pad and controller ports.
module apx_xbar_chk
    import apx_pkg::*;
#(
    parameter int N_PORT = 5,
    parameter int N_CTL  = 3,
    parameter int AW     = 7
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_we,
    input logic [AW-1:0]          cfg_addr,
    input logic [REG_W-1:0]       cfg_wdata,
    input logic [REG_W-1:0]       cfg_rdata,
    input port_cfg_t [N_PORT-1:0] port_cfg,
    input ctl_cfg_t  [N_CTL-1:0]  ctl_cfg,
    input logic [N_CTL-1:0]       ctl_bclk_rx,
    input logic [N_CTL-1:0]       ctl_fs_rx,
    input logic [N_PORT-1:0]      pad_bclk_out,
    input logic [N_PORT-1:0]      pad_fs_out,
    input logic [N_PORT-1:0]      pad_clk_oe,
    input logic [N_PORT-1:0]      pad_d1_out,
    input logic [N_PORT-1:0]      pad_d1_oe,
    input logic [N_PORT-1:0]      pad_d2_out,
    input logic [N_PORT-1:0]      pad_d2_oe
);
    assert_reset_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> cfg_rdata == '0);

    assert_misaligned_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr[1:0] != 2'b00) |-> cfg_rdata == '0);

    assert_write_lands_next_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_we) && $past(cfg_addr) == AW'(PORT_REG_BASE))
        |-> port_cfg[0].src == $past(cfg_wdata[SRC_W-1:0]));

    for (genvar p = 0; p < N_PORT; p++) begin : g_port_chk
        assert_ctl_source_drives_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (port_cfg[p].src < SRC_W'(N_CTL)) |-> pad_clk_oe[p]);

        assert_master_releases_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (port_cfg[p].master && port_cfg[p].src >= SRC_W'(PEER_BASE)
             && port_cfg[p].src < SRC_W'(PEER_BASE + N_PORT))
            |-> (!pad_clk_oe[p] && !pad_bclk_out[p] && !pad_fs_out[p]));

        assert_rx_pin1_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
            port_cfg[p].d1_rx |-> (!pad_d1_oe[p] && !pad_d1_out[p]));

        assert_rx_pin2_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
            port_cfg[p].d2_rx |-> (!pad_d2_oe[p] && !pad_d2_out[p]));
    end

    for (genvar c = 0; c < N_CTL; c++) begin : g_ctl_chk
        assert_reserved_clk_port_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_cfg[c].clk_port >= PSEL_W'(N_PORT)) |-> (!ctl_bclk_rx[c] && !ctl_fs_rx[c]));
    end
endmodule

bind audio_port_xbar apx_xbar_chk #(.N_PORT(N_PORT), .N_CTL(N_CTL), .AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .port_cfg     (port_cfg),
    .ctl_cfg      (ctl_cfg),
    .ctl_bclk_rx  (ctl_bclk_rx),
    .ctl_fs_rx    (ctl_fs_rx),
    .pad_bclk_out (pad_bclk_out),
    .pad_fs_out   (pad_fs_out),
    .pad_clk_oe   (pad_clk_oe),
    .pad_d1_out   (pad_d1_out),
    .pad_d1_oe    (pad_d1_oe),
    .pad_d2_out   (pad_d2_out),
    .pad_d2_oe    (pad_d2_oe)
);

// File: tb/tb_audio_port_xbar.sv
// Scoreboard bench: the driver pushes predicted outputs, the monitor compares.
module tb_audio_port_xbar;
    localparam int NP = 5;
    localparam int NC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [NC-1:0] ctl_bclk_tx = '0, ctl_fs_tx = '0, ctl_d1_tx = '0, ctl_d2_tx = '0;
    logic [NC-1:0] ctl_bclk_rx, ctl_fs_rx, ctl_d1_rx, ctl_d2_rx;
    logic [NP-1:0] pad_bclk_in = '0, pad_fs_in = '0, pad_d1_in = '0, pad_d2_in = '0;
    logic [NP-1:0] pad_bclk_out, pad_fs_out, pad_clk_oe, pad_d1_out, pad_d1_oe, pad_d2_out, pad_d2_oe;

    always #10 clk = ~clk;

    audio_port_xbar dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ctl_bclk_tx(ctl_bclk_tx), .ctl_fs_tx(ctl_fs_tx), .ctl_d1_tx(ctl_d1_tx), .ctl_d2_tx(ctl_d2_tx),
        .ctl_bclk_rx(ctl_bclk_rx), .ctl_fs_rx(ctl_fs_rx), .ctl_d1_rx(ctl_d1_rx), .ctl_d2_rx(ctl_d2_rx),
        .pad_bclk_in(pad_bclk_in), .pad_fs_in(pad_fs_in), .pad_d1_in(pad_d1_in), .pad_d2_in(pad_d2_in),
        .pad_bclk_out(pad_bclk_out), .pad_fs_out(pad_fs_out), .pad_clk_oe(pad_clk_oe),
        .pad_d1_out(pad_d1_out), .pad_d1_oe(pad_d1_oe), .pad_d2_out(pad_d2_out), .pad_d2_oe(pad_d2_oe)
    );

    typedef struct {
        string       tag;
        logic [4:0]  bclk, fs, coe, d1, d1oe, d2, d2oe;
        logic [2:0]  cb, cf, c1, c2;
        logic [31:0] rd;
    } obs_t;

    obs_t        sb[$];
    int          vectors = 0;
    int          miscompares = 0;
    bit          done = 1'b0;
    logic [31:0] m_port [NP];
    logic [31:0] m_ctl  [NC];
    logic [31:0] lfsr = 32'hACE1_2468;

    // Reference model built from the requirement text.
    function automatic obs_t predict(input string tag);
        obs_t e;
        e.tag = tag;
        for (int p = 0; p < NP; p++) begin
            int   sel;
            logic sb_, sf_, s1, s2, peer;
            sel = int'(m_port[p][4:0]);
            sb_ = 0; sf_ = 0; s1 = 0; s2 = 0; peer = 0;
            for (int c = 0; c < NC; c++)
                if (sel == c) begin
                    sb_ = ctl_bclk_tx[c]; sf_ = ctl_fs_tx[c]; s1 = ctl_d1_tx[c]; s2 = ctl_d2_tx[c];
                end
            for (int q = 0; q < NP; q++)
                if (sel == 16 + q) begin
                    peer = 1; sb_ = pad_bclk_in[q]; sf_ = pad_fs_in[q]; s1 = pad_d1_in[q]; s2 = pad_d2_in[q];
                end
            e.coe[p]  = !(peer && m_port[p][31]);
            e.bclk[p] = e.coe[p] ? sb_ : 1'b0;
            e.fs[p]   = e.coe[p] ? sf_ : 1'b0;
            e.d1oe[p] = !m_port[p][30];
            e.d1[p]   = m_port[p][30] ? 1'b0 : s1;
            e.d2oe[p] = !m_port[p][29];
            e.d2[p]   = m_port[p][29] ? 1'b0 : s2;
        end
        for (int c = 0; c < NC; c++) begin
            int k0, k1, k2;
            k0 = int'(m_ctl[c][3:0]); k1 = int'(m_ctl[c][27:24]); k2 = int'(m_ctl[c][31:28]);
            e.cb[c] = 0; e.cf[c] = 0; e.c1[c] = 0; e.c2[c] = 0;
            for (int q = 0; q < NP; q++) begin
                if (k0 == q) begin e.cb[c] = pad_bclk_in[q]; e.cf[c] = pad_fs_in[q]; end
                if (k1 == q) e.c1[c] = pad_d1_in[q];
                if (k2 == q) e.c2[c] = pad_d2_in[q];
            end
        end
        e.rd = '0;
        for (int p = 0; p < NP; p++) if (int'(cfg_addr) == 4 * p) e.rd = m_port[p];
        for (int c = 0; c < NC; c++) if (int'(cfg_addr) == 'h40 + 4 * c) e.rd = m_ctl[c];
        return e;
    endfunction

    function automatic obs_t sample();
        obs_t g;
        g.tag = "";
        g.bclk = pad_bclk_out; g.fs = pad_fs_out; g.coe = pad_clk_oe;
        g.d1 = pad_d1_out; g.d1oe = pad_d1_oe; g.d2 = pad_d2_out; g.d2oe = pad_d2_oe;
        g.cb = ctl_bclk_rx; g.cf = ctl_fs_rx; g.c1 = ctl_d1_rx; g.c2 = ctl_d2_rx;
        g.rd = cfg_rdata;
        return g;
    endfunction

    task automatic compare(input obs_t e, input obs_t g);
        vectors++;
        if (g.bclk !== e.bclk || g.fs !== e.fs || g.coe !== e.coe || g.d1 !== e.d1 ||
            g.d1oe !== e.d1oe || g.d2 !== e.d2 || g.d2oe !== e.d2oe || g.cb !== e.cb ||
            g.cf !== e.cf || g.c1 !== e.c1 || g.c2 !== e.c2 || g.rd !== e.rd) begin
            miscompares++;
            $display("FAIL %s actual bclk=%h fs=%h coe=%h d1=%h d1oe=%h d2=%h d2oe=%h cb=%h cf=%h c1=%h c2=%h rd=%h expected bclk=%h fs=%h coe=%h d1=%h d1oe=%h d2=%h d2oe=%h cb=%h cf=%h c1=%h c2=%h rd=%h",
                     e.tag, g.bclk, g.fs, g.coe, g.d1, g.d1oe, g.d2, g.d2oe, g.cb, g.cf, g.c1, g.c2, g.rd,
                     e.bclk, e.fs, e.coe, e.d1, e.d1oe, e.d2, e.d2oe, e.cb, e.cf, e.c1, e.c2, e.rd);
        end
    endtask

    // Monitor: compares every pending prediction midway after each rising edge.
    initial forever begin
        @(posedge clk);
        #5;
        while (sb.size() > 0) compare(sb.pop_front(), sample());
    end

    // Vary every pad and controller line.
    task automatic shuffle();
        for (int i = 0; i < 7; i++) lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        pad_bclk_in = lfsr[4:0];   pad_fs_in = lfsr[9:5];
        pad_d1_in   = lfsr[14:10]; pad_d2_in = lfsr[19:15];
        ctl_bclk_tx = lfsr[22:20]; ctl_fs_tx = lfsr[25:23];
        ctl_d1_tx   = lfsr[28:26]; ctl_d2_tx = lfsr[31:29];
    endtask

    // Model of the register writes (R2 masks and address map).
    task automatic model_write(input logic [6:0] a, input logic [31:0] d);
        for (int p = 0; p < NP; p++) if (int'(a) == 4 * p) m_port[p] = d & 32'hE000_001F;
        for (int c = 0; c < NC; c++) if (int'(a) == 'h40 + 4 * c) m_ctl[c] = d & 32'hFF00_000F;
    endtask

    // Driver: one access per cycle, called at a falling edge.
    task automatic step(input string tag, input logic we, input logic [6:0] a, input logic [31:0] d);
        cfg_we = we; cfg_addr = a; cfg_wdata = d;
        if (we) begin
            #1;
            compare(predict({"R3 before edge, ", tag}), sample());
            model_write(a, d);
        end
        sb.push_back(predict(tag));
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr(input string tag, input logic [6:0] a, input logic [31:0] d);
        step(tag, 1'b1, a, d);
    endtask

    task automatic look(input string tag, input logic [6:0] a, input int n);
        for (int i = 0; i < n; i++) begin
            shuffle();
            step(tag, 1'b0, a, 32'h0);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 50000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) m_port[p] = '0;
        for (int c = 0; c < NC; c++) m_ctl[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of every register and default routing
        for (int p = 0; p < NP; p++) look("R1 reset port reg", 7'(4 * p), 1);
        for (int c = 0; c < NC; c++) look("R1 reset ctl reg", 7'('h40 + 4 * c), 1);
        // R4: ports take controller lines, master bit has no effect
        wr("R4 port1 to ctl2", 7'h00, 32'h0000_0001);
        wr("R4 port2 to ctl3", 7'h04, 32'h0000_0002);
        look("R4 ctl routing", 7'h00, 3);
        wr("R4 master with ctl source", 7'h00, 32'h8000_0002);
        look("R4 master ignored for ctl", 7'h00, 2);
        // R11: broadcast of one controller to three ports
        wr("R11 port3", 7'h08, 32'h0000_0001);
        wr("R11 port4", 7'h0C, 32'h0000_0001);
        wr("R11 port5", 7'h10, 32'h0000_0001);
        look("R11 broadcast", 7'h10, 3);
        // R5: slave link to port 4
        wr("R5 port2 slave of port4", 7'h04, 32'h0000_0013);
        look("R5 slave clocks", 7'h04, 3);
        // R6: master link releases the clock pins
        wr("R6 port2 master", 7'h04, 32'h8000_0013);
        look("R6 master clocks", 7'h04, 2);
        // R7: pin directions, independent per pin
        wr("R7 pin1 rx", 7'h0C, 32'h4000_0001);
        look("R7 pin1 rx pin2 tx", 7'h0C, 2);
        wr("R7 pin2 rx on peer", 7'h0C, 32'h2000_0012);
        look("R7 pin2 rx pin1 tx", 7'h0C, 2);
        wr("R7 both rx", 7'h0C, 32'h6000_0010);
        look("R7 both rx", 7'h0C, 1);
        // R8: reserved source codes
        wr("R8 code 5", 7'h10, 32'h0000_0005);  look("R8 code 5", 7'h10, 1);
        wr("R8 code 15", 7'h10, 32'h0000_000F); look("R8 code 15", 7'h10, 1);
        wr("R8 code 21", 7'h10, 32'h0000_0015); look("R8 code 21", 7'h10, 1);
        wr("R8 code 31 rx1", 7'h10, 32'h4000_001F); look("R8 code 31", 7'h10, 1);
        // R9: independent controller selects
        wr("R9 ctl1", 7'h40, 32'h4000_0002);
        wr("R9 ctl2", 7'h44, 32'h1300_0004);
        wr("R9 ctl3", 7'h48, 32'h2200_0001);
        look("R9 ctl inputs", 7'h44, 4);
        // R10: reserved controller codes
        wr("R10 ctl1 reserved", 7'h40, 32'hF500_0007);
        look("R10 reserved ctl", 7'h40, 2);
        // R2: masks and address map
        wr("R2 port1 all ones", 7'h00, 32'hFFFF_FFFF); look("R2 port mask", 7'h00, 1);
        wr("R2 ctl2 all ones", 7'h44, 32'hFFFF_FFFF);  look("R2 ctl mask", 7'h44, 1);
        wr("R2 unmapped write", 7'h14, 32'hFFFF_FFFF); look("R2 unmapped read", 7'h14, 1);
        wr("R2 misaligned write", 7'h01, 32'h1234_5678);
        look("R2 port1 unchanged", 7'h00, 1);
        look("R2 misaligned read", 7'h02, 1);
        look("R2 gap read", 7'h4C, 1);
        // R12: nonsensical routes take effect as written
        wr("R12 port3 self slave", 7'h08, 32'h0000_0012);
        look("R12 self link", 7'h08, 2);
        wr("R12 mutual master a", 7'h00, 32'h8000_0011);
        wr("R12 mutual master b", 7'h04, 32'h8000_0010);
        look("R12 mutual masters", 7'h04, 2);
        @(posedge clk);
        #8;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule